// File: doc/BRIEF.md
# Indirect Operand Address Resolver

This block works out the effective operand address for a machine with 12-bit data words and 15-bit addresses. A request supplies a 15-bit starting address and a 3-bit data-field value, together with three flags: follow a pointer, bump that pointer, and fetch the operand. When the pointer flag is set, the block reads the word at the starting address and uses it as the pointer. When the bump flag is also set, it adds one to the pointer, wrapping at 12 bits, and stores the result back at the starting address before it goes on. The resolved address takes its upper three bits from the data field and its lower twelve bits from the pointer.

Without the pointer flag the starting address is the result, unchanged. When the operand flag is set, a final read at the resolved address returns the operand. The block drives a single synchronous memory port that makes at most one read or one write per cycle, with read data returned one cycle after the request. A request that asks for a bump but not a pointer is rejected with an error. Each request ends with a one-cycle completion pulse. New requests are taken only while the block is idle.

Top module: `addr_resolver`

## Requirements
- R1: While reset is held, and until the first request, `busy`, `done`, `err`, `mem_en` and `mem_we` are 0.
- R2: A request with `indirect`=0, `autoinc`=0 and `load_op`=0 raises `done` exactly one cycle after it is accepted, returns `final_addr` equal to `init_addr`, and makes no memory access.
- R3: A request with `indirect`=1 reads memory at `init_addr`, and returns `final_addr` with `dfield` in bits 14..12 and the word read (the pointer) in bits 11..0.
- R4: With `indirect`=1 and `autoinc`=1, the pointer becomes (word + 1) mod 4096 (so 12'hFFF becomes 12'h000). It is written back at `init_addr` before any operand read, and the incremented value is used in `final_addr`.
- R5: A request with `autoinc`=1 and `indirect`=0 is illegal. It makes no memory access, and one cycle after acceptance it raises `done` together with `err`=1 and `final_addr`=`init_addr`. `err` is 0 on every other completion.
- R6: When `load_op`=1 on a legal request, memory is read at `final_addr` and the word read appears on `operand` while `done` is high. When `load_op`=0, `operand` is 0.
- R7: `done` is high for exactly one cycle per request. On a legal request it rises 1 + 2·indirect + (indirect·autoinc) + 2·load_op cycles after acceptance.
- R8: `start` is accepted only while `busy`=0. `busy` is 1 from the cycle after acceptance up to and including the `done` cycle. A `start` raised while busy, together with whatever it carries, does not change the result of the request in progress.
- R9: The memory port makes at most one access per cycle: a legal request makes exactly indirect + (indirect·autoinc) + load_op accesses, `mem_we` is never 1 without `mem_en`, and there is no access while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, taken when idle |
| init_addr | input | 15 | Starting address (pointer location or direct address) |
| indirect | input | 1 | Follow the pointer stored at `init_addr` |
| autoinc | input | 1 | Increment the pointer and write it back |
| load_op | input | 1 | Read the operand at the resolved address |
| dfield | input | 3 | Data field placed in bits 14..12 of an indirect result |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request flag, valid with `done` |
| final_addr | output | 15 | Resolved address, valid with `done` |
| operand | output | 12 | Loaded operand, valid with `done` |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, one cycle after a read |

## Verification
All eight combinations of the pointer, bump and operand flags are applied with random addresses and data fields. Completion latency and the number of memory accesses therefore show which steps were taken, and the resolved address shows whether the field bits came from the data field or from the starting address. Directed cases cover a pointer of 12'hFFF, which shows that the increment wraps instead of carrying into the field bits. An operand location that aliases the pointer location shows that the write-back happens before the operand read. Strobes raised mid-request, carrying other values, show that only the request taken while idle determines the result.

// File: rtl/addr_resolver_pkg.sv
package addr_resolver_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_READ_PTR     = 3'd1,
    ST_PTR_CAPT     = 3'd2,
    ST_WRITE_PTR    = 3'd3,
    ST_LOAD_OPERAND = 3'd4,
    ST_OPER_CAPT    = 3'd5,
    ST_DONE         = 3'd6
  } res_state_e;

  typedef struct packed {
    logic autoinc;
    logic load;
    logic illegal;
  } req_flags_t;

endpackage

// File: rtl/addr_resolver_rst_sync.sv
module addr_resolver_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/addr_resolver_fsm.sv
module addr_resolver_fsm
  import addr_resolver_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_indirect,
  input  logic       in_load,
  input  logic       in_illegal,
  input  logic       q_autoinc,
  input  logic       q_load,
  output res_state_e state_q,
  output logic       accept
);

  res_state_e state_d;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (in_illegal)       state_d = ST_DONE;
          else if (in_indirect) state_d = ST_READ_PTR;
          else if (in_load)     state_d = ST_LOAD_OPERAND;
          else                  state_d = ST_DONE;
        end
      end
      ST_READ_PTR: state_d = ST_PTR_CAPT;
      ST_PTR_CAPT: begin
        if (q_autoinc)   state_d = ST_WRITE_PTR;
        else if (q_load) state_d = ST_LOAD_OPERAND;
        else             state_d = ST_DONE;
      end
      ST_WRITE_PTR:    state_d = q_load ? ST_LOAD_OPERAND : ST_DONE;
      ST_LOAD_OPERAND: state_d = ST_OPER_CAPT;
      ST_OPER_CAPT:    state_d = ST_DONE;
      ST_DONE:         state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/addr_resolver_dpath.sv
module addr_resolver_dpath
  import addr_resolver_pkg::*;
#(
  parameter  int DATA_W  = 12,
  parameter  int FIELD_W = 3,
  localparam int ADDR_W  = DATA_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  res_state_e        state_q,
  input  logic              accept,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [FIELD_W-1:0] dfield,
  input  req_flags_t        flags_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output req_flags_t        flags_q,
  output logic [ADDR_W-1:0] final_q,
  output logic [DATA_W-1:0] operand_q,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [ADDR_W-1:0]  ptr_loc_q;
  logic [FIELD_W-1:0] field_q;
  logic               req_en;
  logic               ptr_en;
  logic               opnd_en;
  logic [DATA_W-1:0]  ptr_next;
  logic [DATA_W-1:0]  operand_d;

  // clock enables
  assign req_en  = accept;
  assign ptr_en  = (state_q == ST_PTR_CAPT);
  assign opnd_en = accept || (state_q == ST_OPER_CAPT);

  // pointer update wraps inside the word width
  assign ptr_next  = flags_q.autoinc ? DATA_W'(mem_rdata + 1'b1) : mem_rdata;
  assign operand_d = accept ? '0 : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_loc_q <= '0;
      field_q   <= '0;
      flags_q   <= '0;
      final_q   <= '0;
      operand_q <= '0;
    end else begin
      if (req_en) begin
        ptr_loc_q <= init_addr;
        field_q   <= dfield;
        flags_q   <= flags_in;
        final_q   <= init_addr;
      end
      if (ptr_en) begin
        final_q <= {field_q, ptr_next};
      end
      if (opnd_en) begin
        operand_q <= operand_d;
      end
    end
  end

  // single memory port, one access per state
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_loc_q;
    mem_wdata = final_q[DATA_W-1:0];
    unique case (state_q)
      ST_READ_PTR: begin
        mem_en = 1'b1;
      end
      ST_WRITE_PTR: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
      end
      ST_LOAD_OPERAND: begin
        mem_en   = 1'b1;
        mem_addr = final_q;
      end
      default: begin
        mem_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import addr_resolver_pkg::*;
#(
  parameter  int DATA_W  = 12,
  parameter  int FIELD_W = 3,
  localparam int ADDR_W  = DATA_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  init_addr,
  input  logic               indirect,
  input  logic               autoinc,
  input  logic               load_op,
  input  logic [FIELD_W-1:0] dfield,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [ADDR_W-1:0]  final_addr,
  output logic [DATA_W-1:0]  operand,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);

  logic       rst_core_n;
  res_state_e state_q;
  logic       accept;
  req_flags_t flags_in;
  req_flags_t flags_q;

  assign flags_in.autoinc = autoinc & indirect;
  assign flags_in.load    = load_op & ~(autoinc & ~indirect);
  assign flags_in.illegal = autoinc & ~indirect;

  addr_resolver_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  addr_resolver_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (start),
    .in_indirect (indirect),
    .in_load     (load_op),
    .in_illegal  (flags_in.illegal),
    .q_autoinc   (flags_q.autoinc),
    .q_load      (flags_q.load),
    .state_q     (state_q),
    .accept      (accept)
  );

  addr_resolver_dpath #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .state_q   (state_q),
    .accept    (accept),
    .init_addr (init_addr),
    .dfield    (dfield),
    .flags_in  (flags_in),
    .mem_rdata (mem_rdata),
    .flags_q   (flags_q),
    .final_q   (final_addr),
    .operand_q (operand),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);
  assign err  = done & flags_q.illegal;

endmodule

// File: rtl/addr_resolver_chk.sv
module addr_resolver_chk #(
  parameter  int DATA_W  = 12,
  parameter  int FIELD_W = 3,
  localparam int ADDR_W  = DATA_W + FIELD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              indirect,
  input logic              autoinc,
  input logic              load_op,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  // R9: a write is always a memory access
  assert_we_has_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R9: no memory traffic while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: plain direct request finishes on the next cycle
  assert_direct_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !indirect && !autoinc && !load_op) |=> (done && !err));

  // R5: illegal combination finishes with an error on the next cycle
  assert_illegal_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && autoinc && !indirect) |=> (done && err));

  // R5: error only appears with completion
  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R4: write-back carries the pointer just read plus one
  assert_writeback_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == DATA_W'($past(mem_rdata) + 1'b1)));

endmodule

bind addr_resolver addr_resolver_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .indirect  (indirect),
  .autoinc   (autoinc),
  .load_op   (load_op),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/addr_resolver_bench.sv
`timescale 1ns/1ps
module addr_resolver_bench;

  localparam int DATA_W  = 12;
  localparam int FIELD_W = 3;
  localparam int ADDR_W  = DATA_W + FIELD_W;
  localparam int MEM_N   = 1 << DATA_W;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [ADDR_W-1:0]  init_addr;
  logic               indirect;
  logic               autoinc;
  logic               load_op;
  logic [FIELD_W-1:0] dfield;
  logic               busy;
  logic               done;
  logic               err;
  logic [ADDR_W-1:0]  final_addr;
  logic [DATA_W-1:0]  operand;
  logic               mem_en;
  logic               mem_we;
  logic [ADDR_W-1:0]  mem_addr;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  mem_rdata;

  // bench-side memory with a preload port
  logic [DATA_W-1:0] mem [MEM_N];
  logic [DATA_W-1:0] ref_mem [MEM_N];
  logic              tb_fill;
  logic              tb_we;
  logic [DATA_W-1:0] tb_waddr;
  logic [DATA_W-1:0] tb_wdata;
  int                acc_cnt;

  int errors = 0;
  int checks = 0;
  bit timed_out = 0;

  addr_resolver u_addr_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .init_addr(init_addr),
    .indirect(indirect), .autoinc(autoinc), .load_op(load_op), .dfield(dfield),
    .busy(busy), .done(done), .err(err), .final_addr(final_addr), .operand(operand),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] fill_val(int i);
    return DATA_W'(i * 1237 + 291);
  endfunction

  always @(posedge clk) begin
    if (tb_fill) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= fill_val(i);
    end else if (tb_we) begin
      mem[tb_waddr] <= tb_wdata;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr[DATA_W-1:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[DATA_W-1:0]];
    end
    if (mem_en) acc_cnt <= acc_cnt + 1;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(logic [DATA_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
    ref_mem[a] = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // one request, checked against the bench model
  task automatic run_req(logic [ADDR_W-1:0] ia, bit ind, bit inc, bit ld,
                         logic [FIELD_W-1:0] df, bit poke);
    bit                 ill;
    int                 exp_lat;
    int                 exp_acc;
    logic [DATA_W-1:0]  ptr;
    logic [ADDR_W-1:0]  exp_fin;
    logic [DATA_W-1:0]  exp_op;
    int                 acc0;
    int                 cyc;

    ill = inc && !ind;
    exp_op = '0;
    if (ill) begin
      exp_lat = 1; exp_acc = 0; exp_fin = ia;
    end else begin
      exp_lat = 1 + 2*int'(ind) + int'(ind && inc) + 2*int'(ld);
      exp_acc = int'(ind) + int'(ind && inc) + int'(ld);
      exp_fin = ia;
      if (ind) begin
        ptr = ref_mem[ia[DATA_W-1:0]];
        if (inc) begin
          ptr = DATA_W'(ptr + 1);
          ref_mem[ia[DATA_W-1:0]] = ptr;
        end
        exp_fin = {df, ptr};
      end
      if (ld) exp_op = ref_mem[exp_fin[DATA_W-1:0]];
    end

    @(negedge clk);
    check(!busy, "R8", "idle before start", busy, 0);
    acc0 = acc_cnt;
    start = 1'b1; init_addr = ia; indirect = ind; autoinc = inc; load_op = ld; dfield = df;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        if (exp_lat > 1) check(busy, "R8", "busy after accept", busy, 1);
        if (poke && exp_lat > 2) begin
          start = 1'b1; init_addr = ~ia; indirect = ~ind; autoinc = ~inc;
          load_op = ~ld; dfield = ~df;
        end
      end else if (cyc == 2) begin
        start = 1'b0;
      end
    end while (!done && cyc < 20);

    check(cyc == exp_lat, ill ? "R5" : "R7", "done latency", cyc, exp_lat);
    check(final_addr == exp_fin, ill ? "R5" : (inc ? "R4" : "R3"), "final_addr", final_addr, exp_fin);
    check(err == ill, "R5", "err flag", err, ill);
    check(operand == exp_op, "R6", "operand", operand, exp_op);
    check(busy, "R8", "busy during done", busy, 1);
    check((acc_cnt - acc0) == exp_acc, (!ind && !ld) ? "R2" : "R9", "memory accesses",
          acc_cnt - acc0, exp_acc);
    @(negedge clk);
    check(!done, "R7", "done single pulse", done, 0);
    check(mem[ia[DATA_W-1:0]] == ref_mem[ia[DATA_W-1:0]], "R4", "pointer location",
          mem[ia[DATA_W-1:0]], ref_mem[ia[DATA_W-1:0]]);
  endtask

  initial begin
    int r;
    tb_fill = 1'b0; tb_we = 1'b0; tb_waddr = '0; tb_wdata = '0; acc_cnt = 0;
    start = 1'b0; init_addr = '0; indirect = 1'b0; autoinc = 1'b0; load_op = 1'b0; dfield = '0;
    rst_n = 1'b0;
    r = $urandom(32'd1919);
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = fill_val(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err, "R1", "status in reset", {busy, done, err}, 0);
    check(!mem_en && !mem_we, "R1", "memory idle in reset", {mem_en, mem_we}, 0);
    tb_fill = 1'b1;
    @(negedge clk);
    tb_fill = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !mem_en, "R1", "idle after reset", {busy, done, mem_en}, 0);

    // directed corners
    run_req(15'h1234, 0, 0, 0, 3'd5, 0);                  // R2 direct
    run_req(15'h2345, 0, 0, 1, 3'd1, 0);                  // R6 direct load
    run_req(15'h0456, 0, 1, 1, 3'd7, 0);                  // R5 illegal
    preload(12'h010, 12'hFFF);
    run_req(15'h6010, 1, 1, 1, 3'd5, 0);                  // R4 wrap to 0
    preload(12'h020, 12'h01F);
    run_req(15'h0020, 1, 1, 1, 3'd2, 0);                  // R4 operand aliases pointer+1 word
    preload(12'h030, 12'h030);
    run_req(15'h0030, 1, 1, 1, 3'd0, 1);                  // R4 self-alias, R8 poke
    run_req(15'h7777, 1, 0, 0, 3'd6, 1);                  // R3 plain indirect, R8 poke

    // random mix of all flag combinations
    for (int n = 0; n < 200; n++) begin
      r = $urandom;
      run_req(r[21:7], r[0] | r[1], r[2], r[3], r[6:4], r[22]);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    timed_out = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule